// File: doc/BRIEF.md
# Link Rate Change Sequencer

This block changes the line rate of a serial display link while the chip runs. A request carries a target rate code and a lane count. The block then acts as a master on a simple register bus that reaches the PHY and transmitter register file. It turns the transmitter off and programs the clock-select field. It then reads the PHY status register until the lanes report that the rate change is complete and the PLL reports lock. Last, it turns the transmitter back on. It never issues a PHY reset, because the PHY resets itself internally while the rate changes.

The PHY leaves its completion bits low when the requested rate equals the rate already programmed. In that case the sequencer waits only for PLL lock. Which completion bits are required depends on the lane count. A programmable poll limit ends a wait that never completes. A single-cycle `done` or `error` pulse reports how each request ended. `curRate` shows the last rate that was set successfully.

Top module: `link_rate_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `busValid` are low, and `curRate` reads 3'd1.
- R2: An accepted request produces the following bus accesses, in this order and with no others:
  - a write of 0 to address 0x080, the transmitter-enable field in bit 0;
  - a write of the rate code to address 0x234, with the code in bits 2:0;
  - one or more reads of the status register at 0x280;
  - a write of 1 to address 0x080.
- R3: Only the rate codes 3'd1, 3'd3 and 3'd5 are legal. Any other code gives a one-cycle `error` on the cycle after the request is sampled. It causes no bus access and leaves `curRate` unchanged.
- R4: With two lanes (`reqTwoLanes`=1) and a rate different from `curRate`, the wait ends only when status bits 3:0 read 4'b1111 and bit 4 (PLL lock) reads 1.
- R5: With one lane and a new rate, the wait needs status bits 0, 2 and 4 set. Bits 1 and 3 are ignored.
- R6: When the requested rate equals `curRate`, the wait needs only status bit 4, and bits 3:0 are ignored.
- R7: Suppose the wait has not ended after max(`pollLimit`,1) status reads. The block then raises `error`. It writes the enable (1 to 0x080) first only if bit 4 was set in the last read. Otherwise it ends without that write.
- R8: A successful change gives a one-cycle `done` pulse and loads `curRate` with the new code. `done` and `error` are never high together. `curRate` changes only on success.
- R9: A request is accepted only when the block is idle. While `busy`, `done` or `error` is high, `reqValid` is ignored and causes no extra bus access.
- R10: At most one bus access is outstanding at a time. While `busValid` is high and `busReady` is low, `busValid`, `busAddr`, `busWdata` and `busWrite` hold steady.
- R11: With `busReady` held high and n status reads, `done` rises 2n+4 cycles after the cycle in which the request is driven. A timeout that writes the enable also reports `error` at 2n+4 cycles. A timeout that skips the enable reports `error` at 2n+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqRate | input | 3 | Target rate code |
| reqTwoLanes | input | 1 | 1 = two lanes, 0 = one lane |
| pollLimit | input | TW | Maximum status reads before timeout |
| busValid | output | 1 | Bus access request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Register address |
| busWdata | output | DW | Write data |
| busReady | input | 1 | Access accepted on this edge |
| busRdata | input | RDW | Read data, valid while busReady is high on a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle reject or timeout pulse |
| curRate | output | 3 | Rate code last set successfully |

## Verification
With `busReady` held high, every phase of the sequence has a fixed length: one cycle per write, and two cycles for each status read plus its evaluation. The bench therefore predicts the exact negedge at which `done` or `error` must appear: 1 for a rejected code, 2n+4 or 2n+3 otherwise. It compares that prediction with the count it measured. All bus traffic is logged at the falling edge, with `busReady` set before logging, so each recorded access is the one the next rising edge completes. Runs with a stalling `busReady` check only the order and contents of the accesses, not their timing. After each pulse the bench checks one more negedge to confirm the pulse has dropped.

// File: rtl/link_rate_pkg.sv
package link_rate_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TXOFF,
    OP_CLKSEL,
    OP_STATUS,
    OP_TXON
  } busOp_e;

  typedef struct packed {
    busOp_e op;
    logic   latchReq;
    logic   capStatus;
    logic   setTimeout;
    logic   commitRate;
  } seqStrobe_t;

  localparam logic [2:0] RATE_LOW  = 3'd1;
  localparam logic [2:0] RATE_MID  = 3'd3;
  localparam logic [2:0] RATE_HIGH = 3'd5;

  localparam int LOCK_BIT  = 4;
  localparam int LANE_BITS = 4;

  function automatic logic isRateCode(input logic [2:0] code);
    return (code == RATE_LOW) || (code == RATE_MID) || (code == RATE_HIGH);
  endfunction

endpackage

// File: rtl/link_rate_dp.sv
module link_rate_dp
  import link_rate_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int RDW = 8,
  parameter int TW = 8,
  parameter logic [AW-1:0] TXEN_ADDR = 12'h080,
  parameter logic [AW-1:0] CLKSEL_ADDR = 12'h234,
  parameter logic [AW-1:0] STATUS_ADDR = 12'h280
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strobe,
  input  logic [2:0]     reqRate,
  input  logic           reqTwoLanes,
  input  logic [TW-1:0]  pollLimit,
  input  logic [RDW-1:0] busRdata,
  output logic [AW-1:0]  busAddr,
  output logic           busWrite,
  output logic [DW-1:0]  busWdata,
  output logic           rateValid,
  output logic           statusOk,
  output logic           lockSeen,
  output logic           pollExpired,
  output logic           timedOut,
  output logic [2:0]     curRate
);

  localparam int ONE_LANE_MASK = 4'b0101;

  logic [2:0]     targetQ;
  logic           twoQ;
  logic           sameQ;
  logic [TW-1:0]  limitQ;
  logic [TW-1:0]  countQ;
  logic [RDW-1:0] statusQ;
  logic           timedOutQ;
  logic [2:0]     curRateQ;
  logic [RDW-1:0] needMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ   <= RATE_LOW;
      twoQ      <= 1'b0;
      sameQ     <= 1'b0;
      limitQ    <= '0;
      countQ    <= '0;
      statusQ   <= '0;
      timedOutQ <= 1'b0;
      curRateQ  <= RATE_LOW;
    end else begin
      if (strobe.latchReq) begin
        targetQ   <= reqRate;
        twoQ      <= reqTwoLanes;
        sameQ     <= (reqRate == curRateQ);
        limitQ    <= pollLimit;
        countQ    <= '0;
        timedOutQ <= 1'b0;
      end
      if (strobe.capStatus) begin
        statusQ <= busRdata;
        countQ  <= countQ + TW'(1);
      end
      if (strobe.setTimeout) timedOutQ <= 1'b1;
      if (strobe.commitRate) curRateQ <= targetQ;
    end
  end

  // Required status pattern: lock always; lane completion only on a real change
  always_comb begin
    needMask = '0;
    needMask[LOCK_BIT] = 1'b1;
    if (!sameQ) begin
      if (twoQ) needMask[LANE_BITS-1:0] = '1;
      else      needMask[LANE_BITS-1:0] = LANE_BITS'(ONE_LANE_MASK);
    end
  end

  always_comb begin
    busAddr  = '0;
    busWrite = 1'b0;
    busWdata = '0;
    case (strobe.op)
      OP_TXOFF:  begin busAddr = TXEN_ADDR;   busWrite = 1'b1; end
      OP_CLKSEL: begin busAddr = CLKSEL_ADDR; busWrite = 1'b1; busWdata = DW'(targetQ); end
      OP_STATUS: begin busAddr = STATUS_ADDR; end
      OP_TXON:   begin busAddr = TXEN_ADDR;   busWrite = 1'b1; busWdata = DW'(1); end
      default:   ;
    endcase
  end

  assign rateValid   = isRateCode(reqRate);
  assign statusOk    = ((statusQ & needMask) == needMask);
  assign lockSeen    = statusQ[LOCK_BIT];
  assign pollExpired = (countQ >= limitQ);
  assign timedOut    = timedOutQ;
  assign curRate     = curRateQ;

  // R8: the programmed rate is always one of the legal codes
  assert_rate_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    isRateCode(curRateQ));

  // R4: the enable write is only ever issued with PLL lock in the last read
  assert_lock_before_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_TXON) |-> statusQ[LOCK_BIT]);

  // R7: no status read is started once the poll budget is used up
  assert_poll_budget_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_STATUS) |-> ((countQ < limitQ) || (countQ == '0)));

endmodule

// File: rtl/link_rate_ctrl.sv
module link_rate_ctrl
  import link_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busReady,
  input  logic       rateValid,
  input  logic       statusOk,
  input  logic       lockSeen,
  input  logic       pollExpired,
  input  logic       timedOut,
  output seqStrobe_t strobe,
  output logic       busValid,
  output logic       busy,
  output logic       done,
  output logic       error
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TXOFF, ST_CLKSEL, ST_POLL, ST_EVAL, ST_TXON, ST_OK, ST_FAIL
  } seqState_e;

  seqState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '{op: OP_NONE, default: 1'b0};
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (rateValid) begin
            strobe.latchReq = 1'b1;
            stateD = ST_TXOFF;
          end else begin
            stateD = ST_FAIL;
          end
        end
      end
      ST_TXOFF: begin
        strobe.op = OP_TXOFF;
        if (busReady) stateD = ST_CLKSEL;
      end
      ST_CLKSEL: begin
        strobe.op = OP_CLKSEL;
        if (busReady) stateD = ST_POLL;
      end
      ST_POLL: begin
        strobe.op = OP_STATUS;
        if (busReady) begin
          strobe.capStatus = 1'b1;
          stateD = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (statusOk) begin
          stateD = ST_TXON;
        end else if (pollExpired) begin
          strobe.setTimeout = 1'b1;
          stateD = lockSeen ? ST_TXON : ST_FAIL;
        end else begin
          stateD = ST_POLL;
        end
      end
      ST_TXON: begin
        strobe.op = OP_TXON;
        if (busReady) begin
          if (timedOut) begin
            stateD = ST_FAIL;
          end else begin
            strobe.commitRate = 1'b1;
            stateD = ST_OK;
          end
        end
      end
      ST_OK:   stateD = ST_IDLE;
      ST_FAIL: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign busValid = (strobe.op != OP_NONE);
  assign busy     = (stateQ != ST_IDLE) && (stateQ != ST_OK) && (stateQ != ST_FAIL);
  assign done     = (stateQ == ST_OK);
  assign error    = (stateQ == ST_FAIL);

  // R8: a request ends in exactly one kind of pulse
  assert_one_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R8: success is reported only right after an accepted enable write
  assert_done_after_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busValid && busReady && (strobe.op == OP_TXON)));

  // R10: a stalled access is not withdrawn
  assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid);

  // R9: no bus traffic outside an active sequence
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busValid);

endmodule

// File: rtl/link_rate_seq.sv
module link_rate_seq
  import link_rate_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int RDW = 8,
  parameter int TW = 8,
  parameter logic [AW-1:0] TXEN_ADDR = 12'h080,
  parameter logic [AW-1:0] CLKSEL_ADDR = 12'h234,
  parameter logic [AW-1:0] STATUS_ADDR = 12'h280
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [2:0]     reqRate,
  input  logic           reqTwoLanes,
  input  logic [TW-1:0]  pollLimit,
  output logic           busValid,
  output logic           busWrite,
  output logic [AW-1:0]  busAddr,
  output logic [DW-1:0]  busWdata,
  input  logic           busReady,
  input  logic [RDW-1:0] busRdata,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic [2:0]     curRate
);

  seqStrobe_t strobe;
  logic rateValid, statusOk, lockSeen, pollExpired, timedOut;

  link_rate_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busReady(busReady),
    .rateValid(rateValid), .statusOk(statusOk), .lockSeen(lockSeen),
    .pollExpired(pollExpired), .timedOut(timedOut), .strobe(strobe),
    .busValid(busValid), .busy(busy), .done(done), .error(error)
  );

  link_rate_dp #(
    .AW(AW), .DW(DW), .RDW(RDW), .TW(TW),
    .TXEN_ADDR(TXEN_ADDR), .CLKSEL_ADDR(CLKSEL_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRate(reqRate),
    .reqTwoLanes(reqTwoLanes), .pollLimit(pollLimit), .busRdata(busRdata),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .rateValid(rateValid), .statusOk(statusOk), .lockSeen(lockSeen),
    .pollExpired(pollExpired), .timedOut(timedOut), .curRate(curRate)
  );

  // R10: address, data and direction hold while an access is stalled
  assert_stable_access_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> ($stable(busAddr) && $stable(busWdata) && $stable(busWrite)));

endmodule

// File: tb/link_rate_seq_test.sv
module link_rate_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int RDW = 8;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqRate = 3'd0;
  logic reqTwoLanes = 1'b0;
  logic [TW-1:0] pollLimit = '0;
  logic busValid, busWrite, busy, done, error;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic busReady = 1'b1;
  logic [RDW-1:0] busRdata = '0;
  logic [2:0] curRate;

  link_rate_seq #(.AW(AW), .DW(DW), .RDW(RDW), .TW(TW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRate(reqRate),
    .reqTwoLanes(reqTwoLanes), .pollLimit(pollLimit), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .busy(busy), .done(done),
    .error(error), .curRate(curRate)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Register-file model, logged at the falling edge
  int readyMode = 0;
  int phase = 0;
  int txCount = 0;
  int readsSeen = 0;
  int goodAfter = 0;
  logic [RDW-1:0] statusGood = '0;
  logic [RDW-1:0] statusBad = '0;
  logic [AW-1:0] logAddr [64];
  logic [DW-1:0] logData [64];
  bit logWr [64];
  bit prevStall = 0;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevData = '0;
  int holdBad = 0;

  always @(negedge clk) begin
    phase++;
    busReady = (readyMode == 0) ? 1'b1 : ((phase % 3) == 0);
    if (prevStall && (!busValid || busAddr != prevAddr || busWdata != prevData)) holdBad++;
    prevStall = busValid && !busReady;
    prevAddr = busAddr;
    prevData = busWdata;
    if (busValid && busReady) begin
      if (!busWrite) begin
        busRdata = (readsSeen >= goodAfter) ? statusGood : statusBad;
        readsSeen++;
      end
      if (txCount < 64) begin
        logAddr[txCount] = busAddr;
        logData[txCount] = busWdata;
        logWr[txCount] = busWrite;
      end
      txCount++;
    end
  end

  int curModel = 1;

  task automatic runReq(input int rate, input bit two, input int limit, input int gA,
                        input int good, input int bad, input int mode, input bit inject);
    int lat;
    bit gotDone, gotErr, valid, ok, expEnable;
    int mask, lim, n, v, expTx, expLat, baseTx;
    readyMode = mode;
    goodAfter = gA;
    statusGood = RDW'(good);
    statusBad = RDW'(bad);
    readsSeen = 0;
    txCount = 0;
    @(negedge clk);
    reqRate = 3'(rate);
    reqTwoLanes = two;
    pollLimit = TW'(limit);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!(done || error) && lat < 400) begin
      @(negedge clk);
      lat++;
      if (inject && lat == 3) begin
        reqValid = 1'b1;
        reqRate = (rate == 5) ? 3'd3 : 3'd5;
      end else begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    gotDone = done;
    gotErr = error;
    check(lat < 400, "R11 sequence finished", lat, 0);

    // Expected outcome from the requirements
    valid = (rate == 1) || (rate == 3) || (rate == 5);
    mask = (rate == curModel) ? 16 : (two ? 31 : 21);
    lim = (limit == 0) ? 1 : limit;
    n = 0; ok = 0; v = 0;
    while (!ok && n < lim) begin
      v = (n >= gA) ? good : bad;
      n++;
      if ((v & mask) == mask) ok = 1;
    end
    if (!valid) begin
      check(gotErr && !gotDone, "R3 illegal code error", {gotDone, gotErr}, 1);
      check(txCount == 0, "R3 no bus access", txCount, 0);
      check(lat == 1, "R3 error timing", lat, 1);
      check(curRate == 3'(curModel), "R3 rate unchanged", curRate, curModel);
    end else begin
      expEnable = ok || (((v >> 4) & 1) == 1);
      expTx = 2 + n + (expEnable ? 1 : 0);
      expLat = expEnable ? 2*n + 4 : 2*n + 3;
      if (ok) check(gotDone && !gotErr, "R4 R5 R6 success", {gotDone, gotErr}, 2);
      else    check(gotErr && !gotDone, "R7 timeout error", {gotDone, gotErr}, 1);
      check(txCount == expTx, "R2 R7 access count", txCount, expTx);
      check(logWr[0] && logAddr[0] == 12'h080 && logData[0][0] == 1'b0,
            "R2 disable first", logAddr[0], 12'h080);
      check(logWr[1] && logAddr[1] == 12'h234 && logData[1][2:0] == 3'(rate),
            "R2 clock select second", logData[1], rate);
      baseTx = 0;
      for (int i = 2; i < 2 + n && i < 64; i++)
        if (logWr[i] || logAddr[i] != 12'h280) baseTx++;
      check(baseTx == 0, "R2 status reads", baseTx, 0);
      if (expEnable && expTx <= 64)
        check(logWr[expTx-1] && logAddr[expTx-1] == 12'h080 && logData[expTx-1] == 1,
              "R7 R2 enable written", logData[expTx-1], 1);
      if (mode == 0) check(lat == expLat, "R11 result latency", lat, expLat);
      if (ok) curModel = rate;
      check(curRate == 3'(curModel), "R8 current rate", curRate, curModel);
    end
    @(negedge clk);
    check(!done && !error, "R8 single-cycle pulse", {done, error}, 0);
    if (inject) begin
      baseTx = txCount;
      repeat (8) @(negedge clk);
      check(txCount == baseTx && !busy, "R9 request while busy ignored", txCount, baseTx);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !busValid, "R1 reset outputs", {busy, done, error, busValid}, 0);
    check(curRate == 3'd1, "R1 reset rate", curRate, 1);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep every code and both lane counts; stall the bus on odd combinations
    for (int r = 0; r < 8; r++)
      for (int t = 0; t < 2; t++)
        runReq(r, t[0], 8, 2, 8'h1F, 8'h00, (r + t) % 2, 1'b0);

    // R6: same rate needs lock only
    runReq(curModel, 1'b1, 6, 0, 8'h10, 8'h10, 0, 1'b0);
    // R7: new rate, lock only, times out and still re-enables
    runReq((curModel == 1) ? 3 : 1, 1'b1, 4, 0, 8'h10, 8'h10, 0, 1'b0);
    // R7: no lock, no enable write
    runReq((curModel == 5) ? 3 : 5, 1'b0, 3, 0, 8'h0F, 8'h0F, 0, 1'b0);
    // R5: one lane passes on bits 0,2,4
    runReq((curModel == 3) ? 5 : 3, 1'b0, 5, 1, 8'h15, 8'h05, 0, 1'b0);
    // R4: same pattern fails with two lanes
    runReq((curModel == 1) ? 5 : 1, 1'b1, 3, 0, 8'h15, 8'h15, 0, 1'b0);
    // R5: bits 1,3 alone are not enough
    runReq((curModel == 1) ? 5 : 1, 1'b0, 2, 0, 8'h1A, 8'h1A, 0, 1'b0);
    // R7: zero limit means one read
    runReq((curModel == 3) ? 1 : 3, 1'b1, 0, 0, 8'h00, 8'h00, 0, 1'b0);
    // R9: request injected while busy, with and without stalls
    runReq((curModel == 5) ? 1 : 5, 1'b1, 8, 1, 8'h1F, 8'h00, 0, 1'b1);
    runReq((curModel == 3) ? 1 : 3, 1'b0, 8, 2, 8'h15, 8'h00, 1, 1'b1);

    check(holdBad == 0, "R10 stalled access held", holdBad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule